// File: doc/BRIEF.md
# Three-Source Interrupt Flag Controller

This block keeps sticky event flags for three interrupt sources: the periodic divider tap, the alarm match and the end of a calendar update. Each source sends a single-cycle event strobe. The strobe sets that source's flag whether or not the source is enabled. The three enable bits come in from a control register that lives elsewhere. The block only reads them and never changes them.

A summary bit marks that at least one flag is set while its enable is also set. The active-low interrupt request line follows that summary bit. A bus read of the flag register is signalled by a read strobe. That read clears every flag and the summary bit in one step. An event that arrives in the same cycle as the read still leaves its flag set.

The flag register and the request line are both registered. A cleared condition therefore releases the request line on the same clock edge that takes the clearing read.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flag register reads 8'h00 and `irq_n` is high.
- R2: An event strobe that is high at a clock edge sets its flag after that edge, whatever the value of its enable. The periodic flag is bit 6, the alarm flag is bit 5 and the update-ended flag is bit 4.
- R3: Bits 3 down to 0 of the flag register always read as zero.
- R4: Bit 7 (summary) is one after an edge exactly when, at that edge, some source has its next flag value at one and its enable input at one.
- R5: `irq_n` is low exactly when bit 7 of the flag register is one.
- R6: A read strobe high at an edge clears all three flags and bit 7 after that edge, and releases `irq_n` at that same edge, provided no event arrives with it.
- R7: An event strobe that is high at the same edge as a read strobe leaves its own flag set after the clear. The summary bit then follows R4.
- R8: A flag set while its enable is zero does not pull `irq_n` low. If that enable rises later and the flag is still set, `irq_n` goes low one edge after the enable is seen high. If the enable falls again, `irq_n` is released one edge later.
- R9: A set flag stays set until a read strobe. Repeated events leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_periodic | input | 1 | Periodic divider event strobe |
| ev_alarm | input | 1 | Alarm match event strobe |
| ev_update | input | 1 | Update-ended event strobe |
| en_periodic | input | 1 | Periodic interrupt enable (from control register) |
| en_alarm | input | 1 | Alarm interrupt enable (from control register) |
| en_update | input | 1 | Update-ended interrupt enable (from control register) |
| flag_rd | input | 1 | Read strobe for the flag register (clear on read) |
| flag_reg | output | 8 | Flag register contents: summary bit 7, flags in bits 6..4, zeros in bits 3..0 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The flag register and the request line are both registered outputs. A wrong flag, summary or request state therefore appears on the ports one clock edge after the input pattern that causes it. Every cycle the bench compares the whole register byte and `irq_n` against a model. A flag that fails to stick, or fails to clear, shows as a wrong bit in the same cycle. A summary bit that ignores an enable shows on both bit 7 and `irq_n` at once. The same-edge read and event case is driven on purpose, because a clear that wins over the event would drop that event with no other trace.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
    // Source indices inside the flag vector
    localparam int NSRC     = 3;
    localparam int SRC_UPD  = 0;
    localparam int SRC_ALM  = 1;
    localparam int SRC_PER  = 2;
    // Register layout: flags start at bit FLAG_LSB, summary at SUM_BIT
    localparam int FLAG_LSB = 4;
    localparam int SUM_BIT  = FLAG_LSB + NSRC;

    typedef struct packed {
        logic [NSRC-1:0] flags;
        logic            irqf;
    } ifc_state_t;
endpackage

// File: rtl/irq_flag_cell.sv
// Next-value logic for one sticky flag: set by event, cleared by read,
// event wins over a clear in the same cycle.
module irq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic ev,
    input  logic rd,
    input  logic flag_q,
    output logic flag_d
);
    always_comb begin
        flag_d = flag_q;
        if (rd) begin
            flag_d = 1'b0;
        end
        if (ev) begin
            flag_d = 1'b1;
        end
    end

    // R2 / R7: an event always leaves the flag set
    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> flag_q);
    // R9: without a read the flag is sticky
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !rd) |=> flag_q);
    // R6: a read with no event clears the flag
    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !ev) |=> !flag_q);
endmodule

// File: rtl/irq_summary.sv
// Combines next flag values with enables into the next summary bit.
module irq_summary #(
    parameter int N = 3
) (
    input  logic [N-1:0] flags_d,
    input  logic [N-1:0] en,
    output logic         irqf_d
);
    logic [N-1:0] pend;

    generate
        for (genvar i = 0; i < N; i++) begin : g_pend
            assign pend[i] = flags_d[i] & en[i];
        end
    endgenerate

    always_comb begin
        irqf_d = |pend;
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_flag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_periodic,
    input  logic              ev_alarm,
    input  logic              ev_update,
    input  logic              en_periodic,
    input  logic              en_alarm,
    input  logic              en_update,
    input  logic              flag_rd,
    output logic [DATA_W-1:0] flag_reg,
    output logic              irq_n
);
    localparam int ZERO_W = FLAG_LSB;

    ifc_state_t      state_d, state_q;
    logic [NSRC-1:0] ev_vec;
    logic [NSRC-1:0] en_vec;
    logic [NSRC-1:0] flags_nx;
    logic            irqf_nx;

    always_comb begin
        ev_vec          = '0;
        en_vec          = '0;
        ev_vec[SRC_UPD] = ev_update;
        ev_vec[SRC_ALM] = ev_alarm;
        ev_vec[SRC_PER] = ev_periodic;
        en_vec[SRC_UPD] = en_update;
        en_vec[SRC_ALM] = en_alarm;
        en_vec[SRC_PER] = en_periodic;
    end

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_cell
            irq_flag_cell u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .ev     (ev_vec[i]),
                .rd     (flag_rd),
                .flag_q (state_q.flags[i]),
                .flag_d (flags_nx[i])
            );
        end
    endgenerate

    irq_summary #(.N(NSRC)) u_sum (
        .flags_d (flags_nx),
        .en      (en_vec),
        .irqf_d  (irqf_nx)
    );

    always_comb begin
        state_d       = state_q;
        state_d.flags = flags_nx;
        state_d.irqf  = irqf_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        flag_reg                          = '0;
        flag_reg[ZERO_W-1:0]              = '0;
        flag_reg[FLAG_LSB +: NSRC]        = state_q.flags;
        flag_reg[SUM_BIT]                 = state_q.irqf;
        irq_n                             = ~state_q.irqf;
    end

    // R4: summary implies a flag whose enable was high at the setting edge
    p_summary_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.irqf |-> ((state_q.flags & $past(en_vec)) != '0));
    // R6: a read with no enabled event releases the request line
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && ((ev_vec & en_vec) == '0)) |=> irq_n);
    // R8: with every enable low the request line stays released
    p_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_vec == '0) |=> irq_n);
    // R3: low nibble reads zero
    p_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flag_reg[ZERO_W-1:0] == '0);
endmodule

// File: tb/sim_irq_flag_ctrl.sv
`timescale 1ns/1ps
module sim_irq_flag_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_p = 0, ev_a = 0, ev_u = 0;
    logic       en_p = 0, en_a = 0, en_u = 0;
    logic       rd = 0;
    logic [7:0] flag_reg;
    logic       irq_n;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    typedef struct {
        logic [7:0] reg_v;
        logic       irqn_v;
        string      tag;
    } exp_t;
    exp_t sb[$];

    // model state
    logic [2:0] m_flags = 3'b000; // {per, alm, upd}

    always #2.5 clk = ~clk;

    irq_flag_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_periodic(ev_p), .ev_alarm(ev_a), .ev_update(ev_u),
        .en_periodic(en_p), .en_alarm(en_a), .en_update(en_u),
        .flag_rd(rd), .flag_reg(flag_reg), .irq_n(irq_n)
    );

    // driver: drive one cycle of inputs and push the expected result
    task automatic step(input logic p, input logic a, input logic u,
                        input logic ep, input logic ea, input logic eu,
                        input logic r, input string tag);
        exp_t e;
        logic [2:0] nf;
        logic       sum;
        @(negedge clk);
        ev_p = p; ev_a = a; ev_u = u;
        en_p = ep; en_a = ea; en_u = eu;
        rd = r;
        nf = r ? {p, a, u} : (m_flags | {p, a, u});
        sum = |(nf & {ep, ea, eu});
        m_flags = nf;
        e.reg_v = {sum, nf, 4'b0000};
        e.irqn_v = ~sum;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: pop and compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                compared++;
                if (flag_reg !== e.reg_v || irq_n !== e.irqn_v) begin
                    mismatched++;
                    $display("FAIL %s: got reg=%h irq_n=%b, expected reg=%h irq_n=%b",
                             e.tag, flag_reg, irq_n, e.reg_v, e.irqn_v);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        compared++;
        if (flag_reg !== 8'h00 || irq_n !== 1'b1) begin
            mismatched++;
            $display("FAIL R1: got reg=%h irq_n=%b, expected reg=00 irq_n=1", flag_reg, irq_n);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2: flags set with enables low, R3 low nibble zero, R8 no irq
        step(1,0,0, 0,0,0, 0, "R2 periodic bit6 disabled");
        step(0,1,0, 0,0,0, 0, "R2 alarm bit5 disabled");
        step(0,0,1, 0,0,0, 0, "R2 update bit4 disabled R3");
        step(0,0,0, 0,0,0, 0, "R8 all flags no enable no irq");
        // R9: repeated events, no change
        step(1,1,1, 0,0,0, 0, "R9 repeat events sticky");
        // R8: raise alarm enable later, irq follows one edge later
        step(0,0,0, 0,1,0, 0, "R8 enable rises irq asserts R4 R5");
        step(0,0,0, 0,0,0, 0, "R8 enable falls irq released");
        // R6: read clears everything
        step(0,0,0, 1,1,1, 1, "R6 read clears all");
        step(0,0,0, 1,1,1, 0, "R6 stays clear R9");
        // R4: enabled event asserts summary
        step(0,0,1, 0,0,1, 0, "R4 update enabled asserts");
        step(0,0,0, 0,0,1, 0, "R9 held until read");
        // R7: event on same edge as read
        step(1,0,0, 1,0,1, 1, "R7 periodic event with read enabled");
        step(0,0,0, 1,0,1, 0, "R7 periodic survives clear");
        step(0,1,0, 0,0,0, 1, "R7 alarm event with read disabled");
        step(0,0,0, 0,0,0, 1, "R6 read releases");
        // R4: mixed enables, only masked source flagged
        step(1,0,1, 0,1,0, 0, "R4 enabled source idle no summary");
        step(0,1,0, 0,1,0, 0, "R4 alarm enabled summary R5");
        step(0,0,0, 0,1,0, 1, "R6 final clear");
        step(0,0,0, 0,0,0, 0, "R1 idle after clear");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule